// File: doc/BRIEF.md
# Reference-Aligned ADC Sample Selector

This block sits in the host logic of a two-channel delta-sigma converter that runs continuously at a rate several times higher than an external square-wave reference. It turns that free-running sample stream into exactly one sample pair per reference period. The pair it keeps is the first one whose data-ready strobe follows a rising reference edge. It also steers the converter's phase. On every falling reference edge it raises a resynchronization pulse after a programmable delay, and moving that delay moves where the kept sample lands inside the period.

A resync restarts the converter's decimation filter, and the converter keeps sending data while the filter settles. The block therefore masks every sample for a programmable settling window after each pulse it issues. If the sample slot of a period falls inside that window, the block raises a sticky flag, which shows that the chosen timing can never produce settled data. A second sticky flag marks any reference period that ends with no accepted sample. A watchdog declares the reference lost when no edge arrives for a set number of clocks, and no resync pulses are issued while the reference is lost.

The serial transfer that fills the channel words is outside this block. The words must be stable when the data-ready strobe falls.

Top module: `ref_aligned_sampler`

## Requirements
- R1: A falling transition on `ref_in` raises `sync_out` exactly 4 + `cfg_sync_delay` clock rising edges after the transition, counted from the first edge after it. This covers two synchronizer stages, edge detection and the delay count. A rising transition never starts a pulse.
- R2: `sync_out` stays high for `cfg_sync_width` clocks. A width of 0 gives a one-clock pulse.
- R3: After each rising reference edge, the first `drdy_n` falling edge that comes strictly later is accepted. `smp_valid` is high for exactly one clock, and `smp_ch0`/`smp_ch1` carry the channel words present at that falling edge. Every other data-ready edge in the period is discarded. A data-ready edge in the same synchronized cycle as the reference rise is not accepted.
- R4: A resync pulse starts a masking window of `cfg_settle` clocks. With the falling reference transition driven at edge count 0 and `cfg_sync_delay` = 0, a data-ready fall driven k edges later is masked when k < `cfg_settle` + 2 and accepted when k = `cfg_settle` + 2. A value of 0 disables masking.
- R5: When the one candidate sample of a period is masked by the settling window, `unsettled_flag` sets and stays set until reset. The candidate is consumed, so no later sample in that period is accepted.
- R6: `miss_flag` sets, and stays set until reset, at any rising reference edge that closes a period with no accepted sample. The first rising edge after reset never sets it.
- R7: `ref_lost` rises once `TIMEOUT_CYC` clocks pass with no reference edge. While it is high, falling edges raise no pulse. The first edge after a loss clears it and does not start a pulse itself.
- R8: While reset is asserted and just after it, `sync_out`, `smp_valid`, `ref_lost`, `miss_flag`, `unsettled_flag` and both sample words are 0.
- R9: `smp_ch0`/`smp_ch1` hold their last accepted values between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_in | input | 1 | External reference square wave, asynchronous |
| drdy_n | input | 1 | Converter data-ready, active low, asynchronous |
| ch0_word | input | DW | Channel 0 conversion word, stable while data-ready falls |
| ch1_word | input | DW | Channel 1 conversion word, stable while data-ready falls |
| cfg_sync_delay | input | CW | Clocks from detected falling reference edge to the resync pulse |
| cfg_sync_width | input | CW | Resync pulse width in clocks (0 acts as 1) |
| cfg_settle | input | CW | Settling mask length in clocks after each resync |
| sync_out | output | 1 | Resync pulse to the converter, active high |
| smp_valid | output | 1 | One-clock strobe for an accepted sample pair |
| smp_ch0 | output | DW | Accepted channel 0 word |
| smp_ch1 | output | DW | Accepted channel 1 word |
| ref_lost | output | 1 | Reference timeout state |
| miss_flag | output | 1 | Sticky: a period closed with no accepted sample |
| unsettled_flag | output | 1 | Sticky: a period's sample slot fell inside the settling window |

## Verification
The hardest case to reach is the settling boundary. A data-ready fall must arrive exactly one clock before, and then exactly at, the end of the mask. That mask was started by a pulse the block issued on its own after a programmable delay. The bench turns off its free-running stimulus generator and drives each transition by hand, counting clock edges from the falling reference transition. It places a re-arming rise between the fall and the data-ready edge, so only the mask decides the outcome. The steady-state runs check the one-per-period rule against a bench-side model. That model replays the same reference and data-ready events at the pins with periods that are not multiples of each other, including a data-ready rate slower than the reference, which forces missed periods.

// File: rtl/ras_pkg.sv
package ras_pkg;

  typedef enum logic [1:0] {
    RS_IDLE  = 2'd0,
    RS_WAIT  = 2'd1,
    RS_PULSE = 2'd2
  } rs_state_e;

endpackage

// File: rtl/ras_edge_sync.sv
// Multi-stage synchronizer followed by a change detector.
module ras_edge_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level_o,
  output logic change_o
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= RST_VAL;
        else        chain_q[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= RST_VAL;
        else        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= RST_VAL;
    else        last_q <= chain_q[STAGES-1];
  end

  assign level_o  = chain_q[STAGES-1];
  assign change_o = chain_q[STAGES-1] ^ last_q;

endmodule

// File: rtl/ras_resync_gen.sv
// Delayed resync pulse launched by a falling reference edge.
module ras_resync_gen
  import ras_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_fall_i,
  input  logic          lost_i,
  input  logic [CW-1:0] cfg_delay_i,
  input  logic [CW-1:0] cfg_width_i,
  output logic          sync_o,
  output logic          start_o
);

  rs_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    start_o = 1'b0;
    unique case (st_q)
      RS_IDLE: begin
      end
      RS_WAIT: begin
        if (cnt_q == '0) begin
          st_d    = RS_PULSE;
          start_o = 1'b1;
          cnt_d   = (cfg_width_i == '0) ? '0 : cfg_width_i - 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      RS_PULSE: begin
        if (cnt_q == '0) st_d = RS_IDLE;
        else             cnt_d = cnt_q - 1'b1;
      end
      default: st_d = RS_IDLE;
    endcase
    if (ref_fall_i && !lost_i) begin
      st_d    = RS_WAIT;
      cnt_d   = cfg_delay_i;
      start_o = 1'b0;
    end
  end

  assign cnt_en = (st_q != RS_IDLE) || (ref_fall_i && !lost_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= RS_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign sync_o = (st_q == RS_PULSE);

  // R7: a falling edge seen while lost leaves an idle generator idle
  a_r7_lost_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_fall_i && lost_i && st_q == RS_IDLE) |=> (st_q == RS_IDLE));

  // R1: the pulse is only entered from the delay phase
  a_r1_pulse_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_o) |-> ($past(st_q) == RS_WAIT));

endmodule

// File: rtl/ras_settle_mask.sv
// Settling window started by each resync pulse.
module ras_settle_mask #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] cfg_settle_i,
  output logic          settling_o
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    if (start_i)            cnt_d = cfg_settle_i;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  assign cnt_en = start_i || (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign settling_o = (cnt_q != '0);

  // R4: a resync with a nonzero window masks the following cycle
  a_r4_window_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && cfg_settle_i != '0) |=> settling_o);

endmodule

// File: rtl/ras_ref_watch.sv
// Reference activity watchdog.
module ras_ref_watch #(
  parameter int TIMEOUT_CYC = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_i,
  output logic lost_o
);

  localparam int             TW    = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0]  LIMIT = TW'(TIMEOUT_CYC - 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          lost_q, lost_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    lost_d = lost_q;
    if (edge_i) begin
      cnt_d  = '0;
      lost_d = 1'b0;
    end else if (cnt_q == LIMIT) begin
      lost_d = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  assign cnt_en = edge_i || (cnt_q != LIMIT) || !lost_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lost_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      lost_q <= lost_d;
    end
  end

  assign lost_o = lost_q;

  // R7: any reference edge clears the lost state
  a_r7_edge_clears: assert property (@(posedge clk) disable iff (!rst_n)
    edge_i |=> !lost_o);

endmodule

// File: rtl/ref_aligned_sampler.sv
module ref_aligned_sampler
  import ras_pkg::*;
#(
  parameter int DW          = 24,
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2,
  parameter int TIMEOUT_CYC = 20000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_in,
  input  logic          drdy_n,
  input  logic [DW-1:0] ch0_word,
  input  logic [DW-1:0] ch1_word,
  input  logic [CW-1:0] cfg_sync_delay,
  input  logic [CW-1:0] cfg_sync_width,
  input  logic [CW-1:0] cfg_settle,
  output logic          sync_out,
  output logic          smp_valid,
  output logic [DW-1:0] smp_ch0,
  output logic [DW-1:0] smp_ch1,
  output logic          ref_lost,
  output logic          miss_flag,
  output logic          unsettled_flag
);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  // edge detection
  logic ref_lvl, ref_chg, ref_rise, ref_fall;
  logic drdy_lvl, drdy_chg, drdy_fall;

  ras_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ref_sync (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .din      (ref_in),
    .level_o  (ref_lvl),
    .change_o (ref_chg)
  );

  ras_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_drdy_sync (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .din      (drdy_n),
    .level_o  (drdy_lvl),
    .change_o (drdy_chg)
  );

  assign ref_rise  = ref_chg &  ref_lvl;
  assign ref_fall  = ref_chg & ~ref_lvl;
  assign drdy_fall = drdy_chg & ~drdy_lvl;

  // watchdog, resync and settling
  logic lost, rs_start, settling;

  ras_ref_watch #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_watch (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .edge_i (ref_chg),
    .lost_o (lost)
  );

  ras_resync_gen #(.CW(CW)) u_resync (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .ref_fall_i  (ref_fall),
    .lost_i      (lost),
    .cfg_delay_i (cfg_sync_delay),
    .cfg_width_i (cfg_sync_width),
    .sync_o      (sync_out),
    .start_o     (rs_start)
  );

  ras_settle_mask #(.CW(CW)) u_settle (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .start_i      (rs_start),
    .cfg_settle_i (cfg_settle),
    .settling_o   (settling)
  );

  // slot selection
  logic armed_q, armed_d;
  logic got_q, got_d;
  logic started_q, started_d;
  logic miss_q, miss_d;
  logic unset_q, unset_d;
  logic valid_q;
  logic accept, drop;
  logic [DW-1:0] ch0_q, ch1_q;

  always_comb begin
    accept    = drdy_fall && armed_q && !ref_rise && !settling;
    drop      = drdy_fall && armed_q && !ref_rise &&  settling;
    armed_d   = armed_q;
    got_d     = got_q;
    if (ref_rise) begin
      armed_d = 1'b1;
      got_d   = 1'b0;
    end else if (drdy_fall) begin
      armed_d = 1'b0;
      if (accept) got_d = 1'b1;
    end
    started_d = started_q | ref_rise;
    miss_d    = miss_q  | (ref_rise & started_q & ~got_q);
    unset_d   = unset_q | drop;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      armed_q   <= 1'b0;
      got_q     <= 1'b0;
      started_q <= 1'b0;
      miss_q    <= 1'b0;
      unset_q   <= 1'b0;
      valid_q   <= 1'b0;
    end else begin
      armed_q   <= armed_d;
      got_q     <= got_d;
      started_q <= started_d;
      miss_q    <= miss_d;
      unset_q   <= unset_d;
      valid_q   <= accept;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      ch0_q <= '0;
      ch1_q <= '0;
    end else if (accept) begin
      ch0_q <= ch0_word;
      ch1_q <= ch1_word;
    end
  end

  assign smp_valid      = valid_q;
  assign smp_ch0        = ch0_q;
  assign smp_ch1        = ch1_q;
  assign ref_lost       = lost;
  assign miss_flag      = miss_q;
  assign unsettled_flag = unset_q;

  // R3: the strobe never lasts two clocks
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_core_n)
    smp_valid |=> !smp_valid);

  // R4: nothing is accepted while the settle window is open
  a_r4_no_accept_settling: assert property (@(posedge clk) disable iff (!rst_core_n)
    smp_valid |-> !$past(settling));

  // R9: sample words only change with a strobe
  a_r9_hold_words: assert property (@(posedge clk) disable iff (!rst_core_n)
    !smp_valid |-> ($stable(smp_ch0) && $stable(smp_ch1)));

  // R6: the missed-period flag rises only on a reference rise
  a_r6_miss_on_rise: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(miss_flag) |-> $past(ref_rise));

  // R5: the unsettled flag rises only on a data-ready edge inside the window
  a_r5_unsettled_cause: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(unsettled_flag) |-> $past(drdy_fall && settling));

endmodule

// File: tb/sim_ref_aligned_sampler.sv
module sim_ref_aligned_sampler;

  localparam int DW = 24;
  localparam int CW = 16;
  localparam int TO = 450;

  logic          clk;
  logic          rst_n;
  logic          ref_in;
  logic          drdy_n;
  logic [DW-1:0] ch0_word, ch1_word;
  logic [CW-1:0] cfg_sync_delay, cfg_sync_width, cfg_settle;
  logic          sync_out, smp_valid, ref_lost, miss_flag, unsettled_flag;
  logic [DW-1:0] smp_ch0, smp_ch1;

  int tests_run, tests_failed;

  // stimulus generator state and bench model
  bit gen_on;
  int half, drp, rp, dp;
  bit rose, fell;
  logic [DW-1:0] seq;
  bit m_armed, m_got, m_started, m_miss;
  int m_acc, m_rises;
  logic [DW-1:0] m_last0, m_last1;

  // output monitor
  int n_acc, n_double;
  logic [DW-1:0] o_last0, o_last1;
  bit prev_valid;

  ref_aligned_sampler #(.DW(DW), .CW(CW), .SYNC_STAGES(2), .TIMEOUT_CYC(TO)) u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .ref_in         (ref_in),
    .drdy_n         (drdy_n),
    .ch0_word       (ch0_word),
    .ch1_word       (ch1_word),
    .cfg_sync_delay (cfg_sync_delay),
    .cfg_sync_width (cfg_sync_width),
    .cfg_settle     (cfg_settle),
    .sync_out       (sync_out),
    .smp_valid      (smp_valid),
    .smp_ch0        (smp_ch0),
    .smp_ch1        (smp_ch1),
    .ref_lost       (ref_lost),
    .miss_flag      (miss_flag),
    .unsettled_flag (unsettled_flag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (gen_on) begin
      rose = 1'b0;
      fell = 1'b0;
      rp++;
      if (rp == half) begin
        rp = 0;
        ref_in = ~ref_in;
        rose = ref_in;
      end
      dp++;
      if (dp == drp) begin
        dp = 0;
        drdy_n = 1'b0;
        seq = seq + 1'b1;
        ch0_word = seq;
        ch1_word = seq ^ 24'hA5A5A5;
        fell = 1'b1;
      end else if (dp == 4) begin
        drdy_n = 1'b1;
      end
      if (rose) begin
        if (m_started && !m_got) m_miss = 1'b1;
        m_armed = 1'b1;
        m_got = 1'b0;
        m_started = 1'b1;
        m_rises++;
      end else if (fell && m_armed) begin
        m_armed = 1'b0;
        m_got = 1'b1;
        m_acc++;
        m_last0 = ch0_word;
        m_last1 = ch1_word;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && smp_valid) begin
      n_acc++;
      o_last0 = smp_ch0;
      o_last1 = smp_ch1;
      if (prev_valid) n_double++;
    end
    prev_valid = smp_valid;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    gen_on = 1'b0;
    rst_n = 1'b0;
    ref_in = 1'b0;
    drdy_n = 1'b1;
    rp = 0; dp = 0; seq = '0;
    m_armed = 0; m_got = 0; m_started = 0; m_miss = 0;
    m_acc = 0; m_rises = 0; m_last0 = '0; m_last1 = '0;
    n_acc = 0; n_double = 0; o_last0 = '0; o_last1 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive ref low at a negedge, then measure pulse latency and width
  task automatic fall_and_measure(output int lat, output int wid);
    ref_in = 1'b0;
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end while (!sync_out && lat < 60);
    wid = 0;
    while (sync_out && wid < 60) begin
      wid++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    wait_neg(2);
    chk(sync_out == 0 && smp_valid == 0, "R8", "strobes in reset", {sync_out, smp_valid}, 0);
    chk(ref_lost == 0 && miss_flag == 0 && unsettled_flag == 0, "R8", "flags in reset",
        {ref_lost, miss_flag, unsettled_flag}, 0);
    do_reset();
    chk(smp_ch0 == 0 && smp_ch1 == 0, "R8", "words after reset", smp_ch0 | smp_ch1, 0);
    chk(sync_out == 0 && smp_valid == 0 && miss_flag == 0, "R8", "outputs after reset",
        {sync_out, smp_valid, miss_flag}, 0);
  endtask

  task automatic t_sync_timing();
    int lat, wid, seen;
    do_reset();
    cfg_sync_delay = 16'd7; cfg_sync_width = 16'd3; cfg_settle = '0;
    ref_in = 1'b1;
    seen = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (sync_out) seen++;
    end
    chk(seen == 0, "R1", "no pulse on rising edge", seen, 0);
    fall_and_measure(lat, wid);
    chk(lat == 11, "R1", "pulse latency delay=7", lat, 11);
    chk(wid == 3, "R2", "pulse width 3", wid, 3);
    cfg_sync_delay = '0; cfg_sync_width = '0;
    ref_in = 1'b1;
    wait_neg(8);
    fall_and_measure(lat, wid);
    chk(lat == 4, "R1", "pulse latency delay=0", lat, 4);
    chk(wid == 1, "R2", "width 0 acts as 1", wid, 1);
  endtask

  task automatic t_stream(input int h, input int d, input int periods, input string tag);
    do_reset();
    cfg_sync_delay = 16'd20; cfg_sync_width = 16'd2; cfg_settle = '0;
    half = h; drp = d;
    gen_on = 1'b1;
    wait_neg(2 * h * periods);
    gen_on = 1'b0;
    drdy_n = 1'b1;
    wait_neg(6);
    chk(n_acc == m_acc, "R3", {tag, " accepted count"}, n_acc, m_acc);
    chk(o_last0 == m_last0 && o_last1 == m_last1, "R3", {tag, " last pair ch0"}, o_last0, m_last0);
    chk(n_double == 0, "R3", {tag, " strobe width"}, n_double, 0);
    chk(miss_flag == m_miss, "R6", {tag, " missed flag"}, miss_flag, m_miss);
    chk(smp_ch0 == m_last0 && smp_ch1 == m_last1, "R9", {tag, " words held"}, smp_ch0, m_last0);
    chk(unsettled_flag == 0, "R5", {tag, " no unsettled"}, unsettled_flag, 0);
  endtask

  task automatic t_never_settles();
    int snap;
    do_reset();
    cfg_sync_delay = '0; cfg_sync_width = 16'd1; cfg_settle = 16'd150;
    half = 100; drp = 31;
    gen_on = 1'b1;
    wait_neg(180);
    snap = n_acc;
    chk(snap == 1, "R3", "first slot before any resync", snap, 1);
    wait_neg(900);
    gen_on = 1'b0;
    drdy_n = 1'b1;
    wait_neg(6);
    chk(n_acc == snap, "R4", "all later slots masked", n_acc, snap);
    chk(unsettled_flag == 1, "R5", "never-settled flag", unsettled_flag, 1);
    chk(miss_flag == 1, "R6", "missed periods flagged", miss_flag, 1);
  endtask

  task automatic t_settle_edge();
    int base;
    do_reset();
    cfg_sync_delay = '0; cfg_sync_width = 16'd1; cfg_settle = 16'd50;
    ref_in = 1'b1;
    wait_neg(8);
    // round 1: data-ready one clock before window end -> masked
    ref_in = 1'b0;
    wait_neg(3);
    ref_in = 1'b1;
    ch0_word = 24'h123456; ch1_word = 24'h654321;
    wait_neg(48);
    drdy_n = 1'b0;
    wait_neg(4);
    drdy_n = 1'b1;
    wait_neg(6);
    chk(n_acc == 0, "R4", "k=settle+1 masked", n_acc, 0);
    chk(unsettled_flag == 1, "R5", "masked slot flagged", unsettled_flag, 1);
    // round 2: data-ready at window end -> accepted
    base = n_acc;
    ref_in = 1'b0;
    wait_neg(3);
    ref_in = 1'b1;
    ch0_word = 24'hABCDEF; ch1_word = 24'h0F0F0F;
    wait_neg(49);
    drdy_n = 1'b0;
    wait_neg(4);
    drdy_n = 1'b1;
    wait_neg(6);
    chk(n_acc == base + 1, "R4", "k=settle+2 accepted", n_acc, base + 1);
    chk(o_last0 == 24'hABCDEF && o_last1 == 24'h0F0F0F, "R3", "captured pair ch0", o_last0, 24'hABCDEF);
  endtask

  task automatic t_lost();
    int lat, wid, seen;
    do_reset();
    cfg_sync_delay = '0; cfg_sync_width = 16'd1; cfg_settle = '0;
    ref_in = 1'b1;
    wait_neg(400);
    chk(ref_lost == 0, "R7", "not lost before timeout", ref_lost, 0);
    wait_neg(80);
    chk(ref_lost == 1, "R7", "lost after timeout", ref_lost, 1);
    ref_in = 1'b0;
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sync_out) seen++;
    end
    chk(seen == 0, "R7", "recovery edge gives no pulse", seen, 0);
    chk(ref_lost == 0, "R7", "lost cleared by edge", ref_lost, 0);
    ref_in = 1'b1;
    wait_neg(8);
    fall_and_measure(lat, wid);
    chk(lat == 4, "R7", "pulses resume after recovery", lat, 4);
  endtask

  initial begin
    tests_run = 0; tests_failed = 0;
    gen_on = 1'b0; half = 100; drp = 31;
    rst_n = 1'b0; ref_in = 1'b0; drdy_n = 1'b1;
    ch0_word = '0; ch1_word = '0; seq = '0;
    cfg_sync_delay = '0; cfg_sync_width = 16'd1; cfg_settle = '0;
    prev_valid = 1'b0;
    n_acc = 0; n_double = 0;
    wait_neg(2);
    t_reset_state();
    t_sync_timing();
    t_stream(100, 31, 10, "R3 fast drdy");
    t_stream(60, 17, 12, "R3 short period");
    chk(m_rises > 0 && n_acc == m_rises, "R3", "one sample per period", n_acc, m_rises);
    t_stream(100, 250, 12, "R6 slow drdy");
    chk(miss_flag == 1, "R6", "slow drdy leaves empty periods", miss_flag, 1);
    t_never_settles();
    t_settle_edge();
    t_lost();
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests_run++;
    tests_failed++;
    $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 200000, 0);
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule